// File: doc/BRIEF.md
# Miss Status Register File with Explicit Targets

This block keeps track of the cache misses that are still outstanding in a write-back, non-blocking cache. It is a small fully associative file. Each entry holds a valid flag, the block address of one outstanding line, and up to four recorded targets. Each target names the word inside the line, the requester, whether it is a read or a write, and the write data for a write. The cache controller presents each miss together with its block address. In the same cycle the block answers whether the miss opens a new entry (primary), joins an existing entry (secondary) or must be retried (stall). Only primary misses produce a request toward the next memory level, so several misses to one line cost a single downstream transfer.

When the next level returns a line, it names the entry by its index. The block then plays the stored targets back one per cycle, in the order they were recorded. Writes are folded into the returned line. Reads are answered with the word as it stands after every earlier write to that entry. After the last target, the merged line is handed out for installation and the entry is freed. A miss that falls on the entry being played back is stalled until the entry has been freed, and on its retry it becomes a primary miss.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is valid: with no miss presented, the primary, secondary and stall flags, the fill request, the replay-busy flag and the line-out strobe are all 0.
- R2: A miss whose block address matches no valid entry, while an entry is free, is flagged primary in the same cycle and takes the lowest-numbered free entry. In the next cycle the fill request strobe is 1 for exactly one cycle, carrying that block address and entry index.
- R3: A miss whose block address matches a valid entry that has a free target slot and is not being played back is flagged secondary. The cycle after it carries no fill request.
- R4: Each target records its word offset explicitly, so several misses to the same word of one line, whether reads or writes, are held together in one entry.
- R5: Each entry holds at most 4 targets. A matching miss that finds all 4 slots used is flagged stall and is not recorded. Every presented miss receives exactly one of the three flags.
- R6: When every entry is valid, a miss that matches none of them is flagged stall, and no fill request follows.
- R7: A fill response names the entry by index and carries the whole line, with word k at bits [32k+31:32k]. From the next cycle, one target per cycle is played back in recording order with its read/write flag, offset, requester and block address. A read returns the line word at its offset, after all earlier writes of that entry have been merged in. A write returns its own data.
- R8: The cycle after the last target has been played back, the line-out strobe is 1 for one cycle, carrying the entry's block address and the line with all writes merged. At the same time replay-busy falls to 0 and the entry is free.
- R9: A miss whose block address matches the entry under playback, including the cycle of its last target, is flagged stall. The same miss presented in the following cycle is flagged primary.
- R10: A freed entry never produces a match: a miss to the address of a retired line allocates again and issues a new fill request.
- R11: A fill response that arrives while a playback is in progress is ignored: the entry it names stays valid and keeps accepting secondary misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss is presented this cycle |
| miss_addr | input | ADDR_W | Block address of the miss |
| miss_ofs | input | 4 | Word offset within the block |
| miss_id | input | 2 | Requester identifier |
| miss_wr | input | 1 | 1 = write miss, 0 = read miss |
| miss_wdata | input | 32 | Write data for a write miss |
| miss_primary | output | 1 | Miss opened a new entry |
| miss_secondary | output | 1 | Miss was added to an existing entry |
| miss_stall | output | 1 | Miss not accepted, retry |
| fill_req_valid | output | 1 | One-cycle request toward the next level |
| fill_req_addr | output | ADDR_W | Block address requested |
| fill_req_idx | output | IDX_W | Entry that will receive the line |
| fill_rsp_valid | input | 1 | Returned line is present |
| fill_rsp_idx | input | IDX_W | Entry the line belongs to |
| fill_rsp_line | input | 512 | Returned line, word k at bits [32k+31:32k] |
| replay_busy | output | 1 | A playback is in progress |
| rpl_valid | output | 1 | A target is played back this cycle |
| rpl_wr | output | 1 | Played target is a write |
| rpl_ofs | output | 4 | Word offset of the played target |
| rpl_id | output | 2 | Requester of the played target |
| rpl_data | output | 32 | Read result or write data |
| rpl_addr | output | ADDR_W | Block address of the entry under playback |
| line_out_valid | output | 1 | Merged line is ready for installation |
| line_out_addr | output | ADDR_W | Block address of the merged line |
| line_out_data | output | 512 | Line with all buffered writes merged |

## Verification
Lookup and retirement can land on the same entry in one cycle. The bench provokes this by presenting a miss to the line under playback exactly in the cycle its last target is played back. It expects a stall there, then holds the miss one more cycle and expects a primary flag, the line-out strobe and a fresh fill request for the same address. A second overlap is also provoked: a fill response for another entry arrives while a playback is running. That entry must still accept a secondary miss once the playback ends.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

    localparam int SLOTS   = 4;
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int CNT_W   = $clog2(SLOTS + 1);
    localparam int OFS_W   = 4;
    localparam int WORDS   = 1 << OFS_W;
    localparam int ID_W    = 2;
    localparam int WORD_W  = 32;
    localparam int LINE_W  = WORDS * WORD_W;

    typedef struct packed {
        logic [OFS_W-1:0]  ofs;
        logic [ID_W-1:0]   id;
        logic              wr;
        logic [WORD_W-1:0] data;
    } target_t;

    typedef enum logic [1:0] {
        MK_NONE,
        MK_PRIMARY,
        MK_SECONDARY,
        MK_STALL
    } miss_kind_e;

    function automatic logic [LINE_W-1:0] merge_word(
        input logic [LINE_W-1:0] line,
        input logic [OFS_W-1:0]  ofs,
        input logic [WORD_W-1:0] w
    );
        logic [LINE_W-1:0] r;
        r = line;
        r[ofs*WORD_W +: WORD_W] = w;
        return r;
    endfunction

endpackage

// File: rtl/mshr_lookup.sv
module mshr_lookup #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 26,
    parameter int IDX_W   = 2
) (
    input  logic [ENTRIES-1:0]             vld,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
    input  logic [ADDR_W-1:0]              key,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx,
    output logic                           free_found,
    output logic [IDX_W-1:0]               free_idx
);

    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags[g] == key);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    always_comb begin
        free_found = ~&vld;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/mshr_replay.sv
module mshr_replay
    import mshr_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [LINE_W-1:0] start_line,
    input  target_t           cur_tgt,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              busy,
    output logic [IDX_W-1:0]  idx,
    output logic [SLOT_W-1:0] slot,
    output logic              retire,
    output logic [WORD_W-1:0] rd_word,
    output logic              line_out_valid,
    output logic [ADDR_W-1:0] line_out_addr,
    output logic [LINE_W-1:0] line_out_data
);

    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] merged;

    assign rd_word = line_q[cur_tgt.ofs*WORD_W +: WORD_W];
    assign merged  = cur_tgt.wr ? merge_word(line_q, cur_tgt.ofs, cur_tgt.data) : line_q;
    assign retire  = busy && ((CNT_W'(slot) + CNT_W'(1)) == cur_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy           <= 1'b0;
            idx            <= '0;
            slot           <= '0;
            line_q         <= '0;
            line_out_valid <= 1'b0;
            line_out_addr  <= '0;
            line_out_data  <= '0;
        end else begin
            line_out_valid <= 1'b0;
            if (busy) begin
                line_q <= merged;
                slot   <= slot + SLOT_W'(1);
                if (retire) begin
                    busy           <= 1'b0;
                    line_out_valid <= 1'b1;
                    line_out_addr  <= cur_addr;
                    line_out_data  <= merged;
                end
            end else if (start) begin
                busy   <= 1'b1;
                idx    <= start_idx;
                slot   <= '0;
                line_q <= start_line;
            end
        end
    end

endmodule

// File: rtl/mshr_file.sv
module mshr_file
    import mshr_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 26,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [OFS_W-1:0]  miss_ofs,
    input  logic [ID_W-1:0]   miss_id,
    input  logic              miss_wr,
    input  logic [WORD_W-1:0] miss_wdata,
    output logic              miss_primary,
    output logic              miss_secondary,
    output logic              miss_stall,
    output logic              fill_req_valid,
    output logic [ADDR_W-1:0] fill_req_addr,
    output logic [IDX_W-1:0]  fill_req_idx,
    input  logic              fill_rsp_valid,
    input  logic [IDX_W-1:0]  fill_rsp_idx,
    input  logic [LINE_W-1:0] fill_rsp_line,
    output logic              replay_busy,
    output logic              rpl_valid,
    output logic              rpl_wr,
    output logic [OFS_W-1:0]  rpl_ofs,
    output logic [ID_W-1:0]   rpl_id,
    output logic [WORD_W-1:0] rpl_data,
    output logic [ADDR_W-1:0] rpl_addr,
    output logic              line_out_valid,
    output logic [ADDR_W-1:0] line_out_addr,
    output logic [LINE_W-1:0] line_out_data
);

    logic [ENTRIES-1:0]             vld;
    logic [ENTRIES-1:0][ADDR_W-1:0] tags;
    logic [CNT_W-1:0]               cnt  [ENTRIES];
    target_t                        tgts [ENTRIES][SLOTS];

    logic             hit, free_found;
    logic [IDX_W-1:0] hit_idx, free_idx;

    logic              rp_busy, rp_retire;
    logic [IDX_W-1:0]  rp_idx;
    logic [SLOT_W-1:0] rp_slot;
    logic [WORD_W-1:0] rp_rd_word;
    target_t           cur_tgt;
    target_t           new_tgt;
    miss_kind_e        kind;
    logic              start;

    mshr_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lookup (
        .vld        (vld),
        .tags       (tags),
        .key        (miss_addr),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .free_found (free_found),
        .free_idx   (free_idx)
    );

    assign cur_tgt = tgts[rp_idx][rp_slot];
    assign start   = fill_rsp_valid && vld[fill_rsp_idx];

    mshr_replay #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_replay (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .start_idx      (fill_rsp_idx),
        .start_line     (fill_rsp_line),
        .cur_tgt        (cur_tgt),
        .cur_cnt        (cnt[rp_idx]),
        .cur_addr       (tags[rp_idx]),
        .busy           (rp_busy),
        .idx            (rp_idx),
        .slot           (rp_slot),
        .retire         (rp_retire),
        .rd_word        (rp_rd_word),
        .line_out_valid (line_out_valid),
        .line_out_addr  (line_out_addr),
        .line_out_data  (line_out_data)
    );

    // Classification of the presented miss
    always_comb begin
        kind = MK_NONE;
        if (miss_valid) begin
            if (hit) begin
                if ((rp_busy && hit_idx == rp_idx) || cnt[hit_idx] == CNT_W'(SLOTS))
                    kind = MK_STALL;
                else
                    kind = MK_SECONDARY;
            end else if (free_found) begin
                kind = MK_PRIMARY;
            end else begin
                kind = MK_STALL;
            end
        end
    end

    assign miss_primary   = (kind == MK_PRIMARY);
    assign miss_secondary = (kind == MK_SECONDARY);
    assign miss_stall     = (kind == MK_STALL);

    assign new_tgt = '{ofs: miss_ofs, id: miss_id, wr: miss_wr, data: miss_wdata};

    // Entry state: valid, tag, target count, fill request
    always_ff @(posedge clk) begin
        if (rst) begin
            vld            <= '0;
            tags           <= '0;
            fill_req_valid <= 1'b0;
            fill_req_addr  <= '0;
            fill_req_idx   <= '0;
            for (int i = 0; i < ENTRIES; i++) cnt[i] <= '0;
        end else begin
            fill_req_valid <= (kind == MK_PRIMARY);
            fill_req_addr  <= miss_addr;
            fill_req_idx   <= free_idx;
            if (kind == MK_PRIMARY) begin
                vld[free_idx]  <= 1'b1;
                tags[free_idx] <= miss_addr;
                cnt[free_idx]  <= CNT_W'(1);
            end else if (kind == MK_SECONDARY) begin
                cnt[hit_idx] <= cnt[hit_idx] + CNT_W'(1);
            end
            if (rp_retire) vld[rp_idx] <= 1'b0;
        end
    end

    // Target slots and write buffer (no reset needed, guarded by counts)
    always_ff @(posedge clk) begin
        if (kind == MK_PRIMARY)
            tgts[free_idx][0] <= new_tgt;
        else if (kind == MK_SECONDARY)
            tgts[hit_idx][cnt[hit_idx][SLOT_W-1:0]] <= new_tgt;
    end

    assign replay_busy = rp_busy;
    assign rpl_valid   = rp_busy;
    assign rpl_wr      = cur_tgt.wr;
    assign rpl_ofs     = cur_tgt.ofs;
    assign rpl_id      = cur_tgt.id;
    assign rpl_data    = cur_tgt.wr ? cur_tgt.data : rp_rd_word;
    assign rpl_addr    = tags[rp_idx];

endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst,
    input logic              miss_valid,
    input logic [ADDR_W-1:0] miss_addr,
    input logic              miss_primary,
    input logic              miss_secondary,
    input logic              miss_stall,
    input logic              fill_req_valid,
    input logic [ADDR_W-1:0] fill_req_addr,
    input logic              replay_busy,
    input logic              rpl_valid,
    input logic [ADDR_W-1:0] rpl_addr,
    input logic              line_out_valid,
    input logic [ADDR_W-1:0] line_out_addr
);

    assert_one_kind_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({miss_primary, miss_secondary, miss_stall}));

    assert_every_miss_answered_R5: assert property (@(posedge clk) disable iff (rst)
        miss_valid |-> $countones({miss_primary, miss_secondary, miss_stall}) == 1);

    assert_fill_after_primary_R2: assert property (@(posedge clk) disable iff (rst)
        miss_primary |=> (fill_req_valid && fill_req_addr == $past(miss_addr)));

    assert_no_fill_otherwise_R3: assert property (@(posedge clk) disable iff (rst)
        !miss_primary |=> !fill_req_valid);

    assert_collision_stalls_R9: assert property (@(posedge clk) disable iff (rst)
        (rpl_valid && miss_valid && miss_addr == rpl_addr) |-> miss_stall);

    assert_retire_after_replay_R8: assert property (@(posedge clk) disable iff (rst)
        line_out_valid |-> ($past(rpl_valid) && !replay_busy));

    assert_retire_addr_R8: assert property (@(posedge clk) disable iff (rst)
        line_out_valid |-> line_out_addr == $past(rpl_addr));

endmodule

bind mshr_file mshr_file_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .miss_valid     (miss_valid),
    .miss_addr      (miss_addr),
    .miss_primary   (miss_primary),
    .miss_secondary (miss_secondary),
    .miss_stall     (miss_stall),
    .fill_req_valid (fill_req_valid),
    .fill_req_addr  (fill_req_addr),
    .replay_busy    (replay_busy),
    .rpl_valid      (rpl_valid),
    .rpl_addr       (rpl_addr),
    .line_out_valid (line_out_valid),
    .line_out_addr  (line_out_addr)
);

// File: tb/mshr_file_tb.sv
module mshr_file_tb;
    import mshr_pkg::*;

    localparam int ENTRIES = 4;
    localparam int ADDR_W  = 26;
    localparam int IDX_W   = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              miss_valid = 1'b0;
    logic [ADDR_W-1:0] miss_addr = '0;
    logic [OFS_W-1:0]  miss_ofs = '0;
    logic [ID_W-1:0]   miss_id = '0;
    logic              miss_wr = 1'b0;
    logic [WORD_W-1:0] miss_wdata = '0;
    logic              miss_primary, miss_secondary, miss_stall;
    logic              fill_req_valid;
    logic [ADDR_W-1:0] fill_req_addr;
    logic [IDX_W-1:0]  fill_req_idx;
    logic              fill_rsp_valid = 1'b0;
    logic [IDX_W-1:0]  fill_rsp_idx = '0;
    logic [LINE_W-1:0] fill_rsp_line = '0;
    logic              replay_busy, rpl_valid, rpl_wr;
    logic [OFS_W-1:0]  rpl_ofs;
    logic [ID_W-1:0]   rpl_id;
    logic [WORD_W-1:0] rpl_data;
    logic [ADDR_W-1:0] rpl_addr;
    logic              line_out_valid;
    logic [ADDR_W-1:0] line_out_addr;
    logic [LINE_W-1:0] line_out_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    mshr_file #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_dut (.*);

    always #10 clk = ~clk;

    localparam logic [ADDR_W-1:0] A_A = 26'h00A0A0;
    localparam logic [ADDR_W-1:0] A_B = 26'h00B0B1;
    localparam logic [ADDR_W-1:0] A_C = 26'h00C0C2;
    localparam logic [ADDR_W-1:0] A_D = 26'h00D0D3;
    localparam logic [ADDR_W-1:0] A_E = 26'h00E0E4;
    localparam logic [WORD_W-1:0] WX  = 32'hDEAD_BEEF;
    localparam logic [WORD_W-1:0] WY  = 32'h0000_0055;

    function automatic logic [LINE_W-1:0] mk_line(input logic [WORD_W-1:0] base,
                                                  input logic [WORD_W-1:0] step);
        logic [LINE_W-1:0] r;
        for (int i = 0; i < WORDS; i++) r[i*WORD_W +: WORD_W] = base + WORD_W'(i) * step;
        return r;
    endfunction

    task automatic chk(input string req, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // kind: 1 primary, 2 secondary, 3 stall; called at a falling edge
    task automatic do_miss(input logic [ADDR_W-1:0] a, input logic [OFS_W-1:0] o,
                           input logic [ID_W-1:0] id, input logic wr, input logic [WORD_W-1:0] d,
                           input int kind, input logic [IDX_W-1:0] exp_idx, input string req);
        logic [2:0] exp_flags;
        miss_valid = 1'b1; miss_addr = a; miss_ofs = o; miss_id = id; miss_wr = wr; miss_wdata = d;
        exp_flags = (kind == 1) ? 3'b100 : (kind == 2) ? 3'b010 : 3'b001;
        #2;
        chk(req, {miss_primary, miss_secondary, miss_stall}, exp_flags);
        @(negedge clk);
        miss_valid = 1'b0;
        chk(req, fill_req_valid, kind == 1);
        if (kind == 1) begin
            chk(req, fill_req_addr, a);
            chk(req, fill_req_idx, exp_idx);
        end
    endtask

    task automatic fill_start(input logic [IDX_W-1:0] idx, input logic [LINE_W-1:0] line);
        fill_rsp_valid = 1'b1; fill_rsp_idx = idx; fill_rsp_line = line;
        @(negedge clk);
        fill_rsp_valid = 1'b0;
    endtask

    task automatic chk_rpl(input logic wr, input logic [OFS_W-1:0] o, input logic [ID_W-1:0] id,
                           input logic [WORD_W-1:0] d, input logic [ADDR_W-1:0] a, input string req);
        #2;
        chk(req, {rpl_valid, rpl_wr, rpl_ofs, rpl_id}, {1'b1, wr, o, id});
        chk(req, rpl_data, d);
        chk(req, rpl_addr, a);
        @(negedge clk);
    endtask

    task automatic t_reset();
        #2;
        chk("R1", {miss_primary, miss_secondary, miss_stall}, 3'b000);
        chk("R1", {fill_req_valid, replay_busy, line_out_valid, rpl_valid}, 4'b0000);
        @(negedge clk);
    endtask

    task automatic t_merge_and_collision();
        logic [LINE_W-1:0] l, m;
        l = mk_line(32'hC000_0000, 32'h1);
        m = merge_word(l, 4'd3, WX);
        do_miss(A_A, 4'd5, 2'd0, 1'b0, '0, 1, 2'd0, "R2");
        do_miss(A_A, 4'd3, 2'd1, 1'b0, '0, 2, 2'd0, "R3");
        do_miss(A_A, 4'd3, 2'd2, 1'b1, WX, 2, 2'd0, "R4");
        do_miss(A_A, 4'd3, 2'd3, 1'b0, '0, 2, 2'd0, "R4");
        do_miss(A_A, 4'd9, 2'd1, 1'b0, '0, 3, 2'd0, "R5");
        fill_start(2'd0, l);
        chk_rpl(1'b0, 4'd5, 2'd0, l[5*WORD_W +: WORD_W], A_A, "R7");
        chk_rpl(1'b0, 4'd3, 2'd1, l[3*WORD_W +: WORD_W], A_A, "R7");
        chk_rpl(1'b1, 4'd3, 2'd2, WX, A_A, "R7");
        // last target: a miss to the same line must stall (R9)
        miss_valid = 1'b1; miss_addr = A_A; miss_ofs = 4'd0; miss_id = 2'd0; miss_wr = 1'b0;
        #2;
        chk("R9", {miss_primary, miss_secondary, miss_stall}, 3'b001);
        chk("R7", {rpl_valid, rpl_wr, rpl_ofs, rpl_id}, {1'b1, 1'b0, 4'd3, 2'd3});
        chk("R7", rpl_data, WX);
        @(negedge clk);
        #2;
        chk("R8", {line_out_valid, replay_busy, rpl_valid}, 3'b100);
        chk("R8", line_out_addr, A_A);
        chk("R8", line_out_data, m);
        chk("R9", {miss_primary, miss_secondary, miss_stall}, 3'b100);
        @(negedge clk);
        miss_valid = 1'b0;
        chk("R10", {fill_req_valid, fill_req_addr, fill_req_idx}, {1'b1, A_A, 2'd0});
        chk("R8", line_out_valid, 1'b0);
    endtask

    task automatic t_full_and_busy_fill();
        logic [LINE_W-1:0] l;
        l = mk_line('0, 32'd3);
        do_miss(A_B, 4'd0, 2'd1, 1'b0, '0, 1, 2'd1, "R2");
        do_miss(A_C, 4'd1, 2'd2, 1'b0, '0, 1, 2'd2, "R2");
        do_miss(A_D, 4'd2, 2'd3, 1'b0, '0, 1, 2'd3, "R2");
        do_miss(A_E, 4'd4, 2'd0, 1'b0, '0, 3, 2'd0, "R6");
        do_miss(A_C, 4'd7, 2'd1, 1'b1, WY, 2, 2'd0, "R3");
        fill_start(2'd2, l);
        // fill for entry 1 while busy: must be ignored (R11)
        fill_rsp_valid = 1'b1; fill_rsp_idx = 2'd1; fill_rsp_line = '1;
        chk_rpl(1'b0, 4'd1, 2'd2, 32'd3, A_C, "R7");
        fill_rsp_valid = 1'b0;
        chk_rpl(1'b1, 4'd7, 2'd1, WY, A_C, "R7");
        #2;
        chk("R8", {line_out_valid, replay_busy}, 2'b10);
        chk("R8", line_out_data, merge_word(l, 4'd7, WY));
        chk("R11", rpl_valid, 1'b0);
        @(negedge clk);
        do_miss(A_B, 4'd8, 2'd2, 1'b0, '0, 2, 2'd0, "R11");
        do_miss(A_E, 4'd4, 2'd0, 1'b0, '0, 1, 2'd2, "R2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_merge_and_collision();
        t_full_and_busy_fill();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule